// File: doc/BRIEF.md
# Five-Address Subtract-and-Branch Processor

This block is a small memory-to-memory processor in which each instruction names every address it needs. An instruction carries an operation code, a destination address, two source addresses, a condition code, and two next-instruction addresses: one used when the condition holds on the result and one used when it does not. The processor keeps no flags register and never adds to its instruction address between instructions. The next instruction address is always one of the two address fields.

Code and data share one single-port memory of 2^AW words. An instruction takes seven consecutive words starting at the instruction address. A sequencer makes one memory access per cycle. It fetches the seven words, reads both sources, computes the result, writes it to the destination, and then loads the chosen next-instruction address. A level `run` input starts and pauses execution. `halted` reports that a halt instruction was reached.

A debug port loads and inspects memory while the core is stopped. It is a valid/ready request channel: a request is taken on a clock edge where `dbg_valid` and `dbg_ready` are both high. While `dbg_ready` is low a request is not taken and must be held to be served later. A read request returns its data one cycle after acceptance, with a one-cycle `dbg_rvalid` pulse. The return channel has no back-pressure.

Top module: `quint_addr_cpu`

## Requirements
- R1: A synchronous active-high reset sets the instruction address to 0, leaves the core stopped, and clears `halted`. Memory contents are not changed by reset.
- R2: An instruction is seven words at consecutive addresses from the instruction address, wrapping modulo 2^AW. Word 0 is the operation, word 1 the destination, word 2 source 1, word 3 source 2, word 4 the condition, word 5 the taken address, and word 6 the not-taken address.
- R3: The two low bits of word 0 select the operation: 1 = add, 2 = subtract (source 1 minus source 2, modulo 2^DW), 3 = bitwise AND. The result is written to the destination address.
- R4: The two low bits of word 4 select the condition on the result: 0 = always, 1 = result is zero, 2 = result is non-zero, 3 = result MSB set. If the condition holds, the next instruction is at the taken address. Otherwise it is at the not-taken address.
- R5: Operation code 0 (low two bits of word 0) halts the core. `halted` rises at the edge that fetches that word, nothing is written to memory, and `halted` stays high regardless of `run` until the next reset.
- R6: A non-halting instruction takes exactly 12 cycles, with one memory access per cycle: seven fetches, two source reads, execute, write, next-address select.
- R7: `run` is sampled when the core is stopped and at the last cycle of each instruction. If `run` is low there, the core stops at that boundary. When `run` rises again, execution resumes at the selected next instruction.
- R8: `dbg_ready` is high only when the core is stopped with `run` low, or when `halted` is high. An accepted write stores `dbg_wdata` at `dbg_addr`. An accepted read returns the word at `dbg_addr` on `dbg_rdata` one cycle later, with `dbg_rvalid` high for that one cycle.
- R9: A debug request made while `dbg_ready` is low has no effect on memory and produces no `dbg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level enable for execution |
| halted | output | 1 | High once a halt instruction was fetched |
| dbg_valid | input | 1 | Debug request valid |
| dbg_ready | output | 1 | Debug request can be accepted |
| dbg_we | input | 1 | 1 = write request, 0 = read request |
| dbg_addr | input | AW | Debug memory address |
| dbg_wdata | input | DW | Debug write data |
| dbg_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| dbg_rdata | output | DW | Read data |

## Verification
The first program is a countdown loop. An always-taken add runs alternately with a subtract that branches on non-zero. It exercises add, subtract, both branch outcomes, and the exact instruction count through the cycle at which `halted` rises. The second program checks AND under a failing zero test, a subtraction that goes negative under the sign condition, and an add under a failing zero test. A decoy instruction sits on each wrong branch path, so a condition evaluated the wrong way changes a memory word that is read back. `run` is dropped mid-instruction to show that the stop lands on a boundary and that execution resumes correctly. A debug write is issued while the core runs, to show it is discarded.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SRC1, ST_SRC2, ST_EXEC, ST_WRITE, ST_NEXT, ST_HALT
  } seq_st_t;

  localparam logic [1:0] OPC_HALT = 2'd0;
  localparam logic [1:0] OPC_ADD  = 2'd1;
  localparam logic [1:0] OPC_SUB  = 2'd2;
  localparam logic [1:0] OPC_AND  = 2'd3;

  localparam logic [1:0] CC_ALWAYS  = 2'd0;
  localparam logic [1:0] CC_ZERO    = 2'd1;
  localparam logic [1:0] CC_NONZERO = 2'd2;
  localparam logic [1:0] CC_NEG     = 2'd3;

  // word positions inside an instruction; the sequencer decodes by index
  localparam int FLD_OP    = 0;
  localparam int FLD_DST   = 1;
  localparam int FLD_SRC1  = 2;
  localparam int FLD_SRC2  = 3;
  localparam int FLD_CC    = 4;
  localparam int FLD_TRUE  = 5;
  localparam int FLD_FALSE = 6;
  localparam int INSTR_WORDS = 7;
  localparam int FIDX_W = $clog2(INSTR_WORDS);
endpackage

// File: rtl/cpu5_mem.sv
module cpu5_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/cpu5_alu.sv
module cpu5_alu
  import cpu5_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]    opc,
  input  logic [1:0]    cc,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result,
  output logic          take
);
  always_comb begin
    unique case (opc)
      OPC_ADD: result = a + b;
      OPC_SUB: result = a - b;
      OPC_AND: result = a & b;
      default: result = '0;
    endcase
  end

  always_comb begin
    unique case (cc)
      CC_ALWAYS:  take = 1'b1;
      CC_ZERO:    take = (result == '0);
      CC_NONZERO: take = (result != '0);
      default:    take = result[DW-1];
    endcase
  end
endmodule

// File: rtl/cpu5_seq.sv
module cpu5_seq
  import cpu5_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  output seq_st_t           state,
  output logic [FIDX_W-1:0] fidx,
  output logic              halted
);
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(INSTR_WORDS - 1);

  logic [AW-1:0] iaddr;
  logic [DW-1:0] ins [INSTR_WORDS];
  logic [DW-1:0] opa, opb, res_q;
  logic          take_q;
  logic [DW-1:0] alu_res;
  logic          alu_take;

  cpu5_alu #(.DW(DW)) u_alu (
    .opc   (ins[FLD_OP][1:0]),
    .cc    (ins[FLD_CC][1:0]),
    .a     (opa),
    .b     (opb),
    .result(alu_res),
    .take  (alu_take)
  );

  always_comb begin
    mem_we    = (state == ST_WRITE);
    mem_wdata = res_q;
    unique case (state)
      ST_SRC1:  mem_addr = ins[FLD_SRC1][AW-1:0];
      ST_SRC2:  mem_addr = ins[FLD_SRC2][AW-1:0];
      ST_WRITE: mem_addr = ins[FLD_DST][AW-1:0];
      default:  mem_addr = iaddr + AW'(fidx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      iaddr  <= '0;
      fidx   <= '0;
      halted <= 1'b0;
      opa    <= '0;
      opb    <= '0;
      res_q  <= '0;
      take_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          fidx <= '0;
          if (run) state <= ST_FETCH;
        end
        ST_FETCH: begin
          ins[fidx] <= mem_rdata;
          if (fidx == '0 && mem_rdata[1:0] == OPC_HALT) begin
            state  <= ST_HALT;
            halted <= 1'b1;
          end else if (fidx == FIDX_LAST) begin
            state <= ST_SRC1;
          end else begin
            fidx <= fidx + 1'b1;
          end
        end
        ST_SRC1: begin
          opa   <= mem_rdata;
          state <= ST_SRC2;
        end
        ST_SRC2: begin
          opb   <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q  <= alu_res;
          take_q <= alu_take;
          state  <= ST_WRITE;
        end
        ST_WRITE: state <= ST_NEXT;
        ST_NEXT: begin
          iaddr <= take_q ? ins[FLD_TRUE][AW-1:0] : ins[FLD_FALSE][AW-1:0];
          fidx  <= '0;
          state <= run ? ST_FETCH : ST_IDLE;
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/quint_addr_cpu.sv
module quint_addr_cpu
  import cpu5_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          halted,
  input  logic          dbg_valid,
  output logic          dbg_ready,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic          dbg_rvalid,
  output logic [DW-1:0] dbg_rdata
);
  seq_st_t           seq_st;
  logic [FIDX_W-1:0] seq_fidx;
  logic [AW-1:0]     core_addr, mem_addr;
  logic              core_we, mem_we;
  logic [DW-1:0]     core_wdata, mem_wdata, mem_rdata;
  logic              dbg_take;

  cpu5_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .mem_rdata(mem_rdata),
    .mem_addr (core_addr),
    .mem_we   (core_we),
    .mem_wdata(core_wdata),
    .state    (seq_st),
    .fidx     (seq_fidx),
    .halted   (halted)
  );

  assign dbg_ready = (seq_st == ST_IDLE && !run) || halted;
  assign dbg_take  = dbg_valid && dbg_ready;
  assign mem_addr  = dbg_ready ? dbg_addr : core_addr;
  assign mem_we    = dbg_ready ? (dbg_take && dbg_we) : core_we;
  assign mem_wdata = dbg_ready ? dbg_wdata : core_wdata;

  cpu5_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk  (clk),
    .addr (mem_addr),
    .we   (mem_we),
    .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rvalid <= 1'b0;
      dbg_rdata  <= '0;
    end else begin
      dbg_rvalid <= dbg_take && !dbg_we;
      if (dbg_take && !dbg_we) dbg_rdata <= mem_rdata;
    end
  end
endmodule

// File: rtl/cpu5_chk.sv
module cpu5_chk
  import cpu5_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              halted,
  input logic              dbg_valid,
  input logic              dbg_ready,
  input logic              dbg_we,
  input logic              dbg_rvalid,
  input seq_st_t           st,
  input logic [FIDX_W-1:0] fidx,
  input logic              mem_we
);
  localparam logic [FIDX_W-1:0] LAST = FIDX_W'(INSTR_WORDS - 1);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == ST_IDLE && !halted));

  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH && fidx != '0 && fidx != LAST) |=>
      (st == ST_FETCH && fidx == $past(fidx) + 1'b1));

  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && st == ST_HALT));

  assert_core_write_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !dbg_ready) |-> (st == ST_WRITE));

  assert_tail_cycles_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SRC1) |=> (st == ST_SRC2) ##1 (st == ST_EXEC) ##1 (st == ST_WRITE) ##1 (st == ST_NEXT));

  assert_boundary_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NEXT && !run) |=> (st == ST_IDLE));

  assert_read_return_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_rvalid |-> $past(dbg_valid && dbg_ready && !dbg_we));

  assert_no_return_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !dbg_ready |=> !dbg_rvalid);
endmodule

bind quint_addr_cpu cpu5_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .halted    (halted),
  .dbg_valid (dbg_valid),
  .dbg_ready (dbg_ready),
  .dbg_we    (dbg_we),
  .dbg_rvalid(dbg_rvalid),
  .st        (seq_st),
  .fidx      (seq_fidx),
  .mem_we    (mem_we)
);

// File: tb/tb_quint_addr_cpu.sv
module tb_quint_addr_cpu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       halted, dbg_ready, dbg_rvalid;
  logic       dbg_valid = 1'b0;
  logic       dbg_we = 1'b0;
  logic [7:0] dbg_addr = '0;
  logic [7:0] dbg_wdata = '0;
  logic [7:0] dbg_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quint_addr_cpu dut (
    .clk(clk), .rst(rst), .run(run), .halted(halted),
    .dbg_valid(dbg_valid), .dbg_ready(dbg_ready), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata)
  );

  // ---------------- behavioural reference ----------------
  // phase: 0 stopped, 1..7 fetch words, 8..12 src1,src2,exec,write,select, 13 halted
  logic [7:0] m_mem [256];
  int         m_ph = 0;
  logic [7:0] m_ia = '0;
  logic       m_rvalid = 1'b0;
  logic [7:0] m_rdata = '0;

  task automatic m_execute();
    logic [7:0] d, s1, s2, t, f, a, b, r;
    logic [1:0] op, cc;
    logic       tk;
    op = m_mem[m_ia][1:0];
    d  = m_mem[8'(m_ia + 1)];
    s1 = m_mem[8'(m_ia + 2)];
    s2 = m_mem[8'(m_ia + 3)];
    cc = m_mem[8'(m_ia + 4)][1:0];
    t  = m_mem[8'(m_ia + 5)];
    f  = m_mem[8'(m_ia + 6)];
    a = m_mem[s1];
    b = m_mem[s2];
    if (op == 2'd1) r = a + b;
    else if (op == 2'd2) r = a - b;
    else r = a & b;
    if (cc == 2'd0) tk = 1'b1;
    else if (cc == 2'd1) tk = (r == 8'd0);
    else if (cc == 2'd2) tk = (r != 8'd0);
    else tk = r[7];
    m_mem[d] = r;
    m_ia = tk ? t : f;
  endtask

  always @(posedge clk) begin
    bit rdy;
    if (rst) begin
      m_ph = 0; m_ia = '0; m_rvalid = 1'b0;
    end else begin
      rdy = (m_ph == 0 && !run) || m_ph == 13;
      m_rvalid = dbg_valid && rdy && !dbg_we;
      if (m_rvalid) m_rdata = m_mem[dbg_addr];
      if (dbg_valid && rdy && dbg_we) m_mem[dbg_addr] = dbg_wdata;
      if (m_ph == 0) begin
        if (run) m_ph = 1;
      end else if (m_ph == 1) begin
        m_ph = (m_mem[m_ia][1:0] == 2'd0) ? 13 : 2;
      end else if (m_ph >= 2 && m_ph <= 11) begin
        m_ph = m_ph + 1;
      end else if (m_ph == 12) begin
        m_execute();
        m_ph = run ? 1 : 0;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      check(halted == (m_ph == 13), "R5 halted", int'(halted), int'(m_ph == 13));
      check(dbg_ready == ((m_ph == 0 && !run) || m_ph == 13), "R8 dbg_ready",
            int'(dbg_ready), int'((m_ph == 0 && !run) || m_ph == 13));
      check(dbg_rvalid == m_rvalid, "R8 dbg_rvalid", int'(dbg_rvalid), int'(m_rvalid));
      if (m_rvalid)
        check(dbg_rdata == m_rdata, "R8 dbg_rdata", int'(dbg_rdata), int'(m_rdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic dbg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    dbg_valid = 1'b1; dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_valid = 1'b0; dbg_we = 1'b0;
  endtask

  task automatic dbg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    dbg_valid = 1'b1; dbg_we = 1'b0; dbg_addr = a;
    @(negedge clk);
    dbg_valid = 1'b0;
    #2 d = dbg_rdata;
  endtask

  task automatic put_instr(input logic [7:0] base, input logic [7:0] op, input logic [7:0] d,
                           input logic [7:0] s1, input logic [7:0] s2, input logic [7:0] cc,
                           input logic [7:0] t, input logic [7:0] f);
    dbg_wr(base, op);
    dbg_wr(8'(base + 1), d);
    dbg_wr(8'(base + 2), s1);
    dbg_wr(8'(base + 3), s2);
    dbg_wr(8'(base + 4), cc);
    dbg_wr(8'(base + 5), t);
    dbg_wr(8'(base + 6), f);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cyc;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    do_reset();
    #2;
    check(halted == 1'b0, "R1 halted after reset", int'(halted), 0);
    check(dbg_ready == 1'b1, "R1 stopped after reset", int'(dbg_ready), 1);

    // Program 1: countdown loop, 5 iterations adding 3 each time
    for (int i = 0; i < 256; i++) dbg_wr(8'(i), 8'h00);
    put_instr(8'd0, 8'd1, 8'hF2, 8'hF2, 8'hF3, 8'd0, 8'd7, 8'd7);   // R3 add, R4 always
    put_instr(8'd7, 8'd2, 8'hF0, 8'hF0, 8'hF1, 8'd2, 8'd0, 8'd14);  // R3 sub, R4 nonzero
    dbg_wr(8'd14, 8'h00);                                           // R5 halt
    dbg_wr(8'hF0, 8'd5); dbg_wr(8'hF1, 8'd1); dbg_wr(8'hF2, 8'd0); dbg_wr(8'hF3, 8'd3);

    @(negedge clk);
    run = 1'b1;
    cyc = 0;
    while (!halted && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) begin dbg_valid = 1'b1; dbg_we = 1'b1; dbg_addr = 8'hF2; dbg_wdata = 8'h99; end
      if (cyc == 6) begin dbg_valid = 1'b0; dbg_we = 1'b0; end
      #2;
    end
    // R6: 10 instructions of 12 cycles, one start edge, one halt fetch edge
    check(cyc == 1 + 12 * 10 + 1, "R6 cycles to halt", cyc, 122);
    repeat (20) @(negedge clk);
    #2 check(halted == 1'b1, "R5 halt holds with run high", int'(halted), 1);
    run = 1'b0;
    dbg_rd(8'hF0, v); check(v == 8'd0, "R3 countdown reached zero", int'(v), 0);
    dbg_rd(8'hF2, v); check(v == 8'd15, "R9 busy write ignored, R4 loop count", int'(v), 15);
    dbg_rd(8'hF3, v); check(v == 8'd3, "R3 source unchanged", int'(v), 3);

    // Program 2: AND, negative branch, zero test, decoy on wrong paths
    do_reset();
    put_instr(8'd0,  8'd3, 8'hF5, 8'hF6, 8'hF7, 8'd1, 8'd28, 8'd7);  // R4 zero fails
    put_instr(8'd7,  8'd2, 8'hF8, 8'hF9, 8'hFA, 8'd3, 8'd14, 8'd28); // R4 neg holds
    put_instr(8'd14, 8'd1, 8'hFB, 8'hFB, 8'hF1, 8'd1, 8'd28, 8'd21); // R4 zero fails
    dbg_wr(8'd21, 8'h04);                                           // low bits 0: halt (R5)
    put_instr(8'd28, 8'd1, 8'hFC, 8'hFC, 8'hF1, 8'd0, 8'd21, 8'd21); // decoy
    dbg_wr(8'hF6, 8'hF0); dbg_wr(8'hF7, 8'h3C); dbg_wr(8'hF9, 8'd2);
    dbg_wr(8'hFA, 8'd5); dbg_wr(8'hFB, 8'h10); dbg_wr(8'hFC, 8'h40);

    @(negedge clk);
    run = 1'b1;
    repeat (17) @(negedge clk);
    run = 1'b0;                 // mid-instruction: stop must land on a boundary (R7)
    cyc = 0;
    #2;
    while (!dbg_ready && cyc < 100) begin @(negedge clk); cyc++; #2; end
    check(cyc >= 1 && cyc <= 12, "R7 stop at boundary", cyc, 12);
    check(halted == 1'b0, "R7 paused not halted", int'(halted), 0);
    repeat (4) @(negedge clk);
    run = 1'b1;
    cyc = 0;
    while (!halted && cyc < 1000) begin @(negedge clk); cyc++; #2; end
    run = 1'b0;
    dbg_rd(8'hF5, v); check(v == 8'h30, "R3 and result", int'(v), 48);
    dbg_rd(8'hF8, v); check(v == 8'hFD, "R3 sub wraps", int'(v), 253);
    dbg_rd(8'hFB, v); check(v == 8'h11, "R4 neg branch taken", int'(v), 17);
    dbg_rd(8'hFC, v); check(v == 8'h40, "R4 decoy not reached", int'(v), 64);
    dbg_rd(8'd3, v);  check(v == 8'hF7, "R2 instruction word intact", int'(v), 247);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule